// File: doc/BRIEF.md
# Overlapping Serial Pattern Detector

This block watches a continuous serial bit stream, one bit per clock, and flags every place where the four most recent bits are 0, 1, 1, 0 in arrival order. It is a Moore machine with five states. Each state records how many leading bits of the pattern are matched at that moment, from none to all four. The output depends only on the state, so a detection appears on `match_o` in the cycle after the final 0 is sampled, and it lasts exactly one clock.

Occurrences that share bits are each reported. When the machine leaves the full-match state it keeps the part of the history that is still a valid prefix, so a stream such as 01101101101 produces a pulse at every completed 0110.

Two asynchronous controls return the machine to its idle state, where no pattern bit is known. One is the active-low reset. The other is a separate active-high clear that can be raised at any time during operation.

Top module: `serial_pattern_det`

## Requirements
- R1: `match_o` is high in the cycle after a rising edge exactly when the four bits sampled on the last four rising edges since the last clear or reset were 0, 1, 1, 0 in arrival order (bit value 0 is logic low on `bit_i`).
- R2: Each detection holds `match_o` high for exactly one clock period, and `match_o` is never high on two consecutive cycles.
- R3: Overlapping occurrences are each detected. After the stream 01101101101, the trailing 0 of one match starts the next, and `match_o` pulses after the 4th, 7th and 10th bits.
- R4: Bits sampled before a clear or reset never count toward a match. The first detection needs four new bits.
- R5: While `clear_i` is high, the machine is held idle and `match_o` is low at once, without waiting for a clock edge, including when it was high just before.
- R6: While `rst_ni` is low, the machine is held idle and `match_o` is low.
- R7: Windows that differ from 0110 in any bit (for example 0100, 0111, 1110, 0010) produce no pulse. A run of 1s does not advance the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. `bit_i` is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Asynchronous clear to idle, active high |
| bit_i | input | 1 | Serial data, one bit per clock |
| match_o | output | 1 | One-cycle pulse when a pattern completes |

## Verification
The assertions assume that `bit_i` is stable around each rising edge and that every edge carries a valid bit, with no idle gaps in the stream. The bench changes `bit_i` only on falling edges and drives a new bit every cycle, whether the bit comes from a fixed pattern or from a pseudo-random generator. The clear is raised on falling edges, and the bench checks the output just after the clear is raised, before any rising edge occurs.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned STATE_W = 3;

  // Number of leading pattern bits matched so far.
  typedef enum logic [STATE_W-1:0] {
    ST_NONE  = 3'd0,
    ST_ONE   = 3'd1,  // "0"
    ST_TWO   = 3'd2,  // "01"
    ST_THREE = 3'd3,  // "011"
    ST_FULL  = 3'd4   // "0110"
  } pd_state_e;
endpackage

// File: rtl/pd_next_state.sv
module pd_next_state
  import pd_pkg::*;
(
  input  pd_state_e state_i,
  input  logic      bit_i,
  output pd_state_e next_o
);
  always_comb begin
    unique case (state_i)
      ST_NONE:  next_o = bit_i ? ST_NONE  : ST_ONE;
      ST_ONE:   next_o = bit_i ? ST_TWO   : ST_ONE;
      ST_TWO:   next_o = bit_i ? ST_THREE : ST_ONE;
      ST_THREE: next_o = bit_i ? ST_NONE  : ST_FULL;
      ST_FULL:  next_o = bit_i ? ST_TWO   : ST_ONE;  // keep overlapping prefix
      default:  next_o = ST_NONE;                    // unused codes recover
    endcase
  end
endmodule

// File: rtl/pd_state_reg.sv
module pd_state_reg
  import pd_pkg::*;
(
  input  logic      clk_i,
  input  logic      clr_ni,
  input  pd_state_e next_i,
  output pd_state_e state_o
);
  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) state_o <= ST_NONE;
    else         state_o <= next_i;
  end
endmodule

// File: rtl/pd_out_decode.sv
module pd_out_decode
  import pd_pkg::*;
(
  input  pd_state_e state_i,
  input  logic      clr_ni,
  output logic      match_o
);
  // Gate with the clear so the output drops at once.
  assign match_o = clr_ni && (state_i == ST_FULL);
endmodule

// File: rtl/serial_pattern_det.sv
module serial_pattern_det
  import pd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic bit_i,
  output logic match_o
);
  logic      clr_n;
  pd_state_e state_q, state_d;

  assign clr_n = rst_ni & ~clear_i;

  pd_next_state i_next (
    .state_i (state_q),
    .bit_i   (bit_i),
    .next_o  (state_d)
  );

  pd_state_reg i_reg (
    .clk_i   (clk_i),
    .clr_ni  (clr_n),
    .next_i  (state_d),
    .state_o (state_q)
  );

  pd_out_decode i_dec (
    .state_i (state_q),
    .clr_ni  (clr_n),
    .match_o (match_o)
  );

  p_match_bits_r1: assert property (@(posedge clk_i) disable iff (!clr_n)
    match_o |-> ($past(bit_i, 1) == 1'b0) && ($past(bit_i, 2) == 1'b1) &&
                ($past(bit_i, 3) == 1'b1) && ($past(bit_i, 4) == 1'b0));

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!clr_n)
    match_o |=> !match_o);

  p_overlap_zero_r3: assert property (@(posedge clk_i) disable iff (!clr_n)
    (state_q == ST_FULL && !bit_i) |=> (state_q == ST_ONE));

  p_overlap_one_r3: assert property (@(posedge clk_i) disable iff (!clr_n)
    (state_q == ST_FULL && bit_i) |=> (state_q == ST_TWO));

  p_clear_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> !match_o);

  p_reset_low_r6: assert property (@(negedge clk_i)
    !rst_ni |-> !match_o);

  p_ones_idle_r7: assert property (@(posedge clk_i) disable iff (!clr_n)
    (state_q == ST_NONE && bit_i) |=> (state_q == ST_NONE));

  p_legal_state_r4: assert property (@(posedge clk_i) disable iff (!clr_n)
    state_q inside {ST_NONE, ST_ONE, ST_TWO, ST_THREE, ST_FULL});
endmodule

// File: tb/test_serial_pattern_det.sv
module test_serial_pattern_det;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0;
  logic bit_i = 1'b0;
  logic match_o;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model: bit history and count since last clear
  logic [3:0] hist = '0;
  int nbits = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk_i = ~clk_i;  // 250 MHz

  serial_pattern_det i_serial_pattern_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .bit_i   (bit_i),
    .match_o (match_o)
  );

  task automatic check(input logic exp, input string tag);
    n_tests++;
    if (match_o !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s: match_o=%b expected=%b at %0t", tag, match_o, exp, $time);
    end
  endtask

  task automatic step(input logic b, input string tag);
    logic exp;
    @(negedge clk_i);
    bit_i = b;
    @(posedge clk_i);
    #1;
    if (rst_ni && !clear_i) begin
      hist = {hist[2:0], b};
      nbits++;
    end
    exp = rst_ni && !clear_i && (nbits >= 4) && (hist == 4'b0110);
    check(exp, tag);
  endtask

  task automatic stream(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) step(s[i] == "1", tag);
  endtask

  task automatic do_clear(input int hold, input string tag);
    @(negedge clk_i);
    clear_i = 1'b1;
    #1;
    check(1'b0, tag);  // immediate, before any rising edge
    nbits = 0;
    hist = '0;
    for (int i = 0; i < hold; i++) step(i[0], tag);
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R6: reset holds output low while clocks run with pattern input
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      bit_i = (i % 4 == 1) || (i % 4 == 2);
      #1;
      check(1'b0, "R6 reset");
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    nbits = 0;

    stream("0110", "R1 single");
    step(1'b1, "R2 pulse ends");
    stream("11110110", "R7 ones idle");
    stream("0100011111100010", "R7 near misses");
    stream("01101101101", "R3 overlap");
    stream("0110011000110", "R3 shared zero");

    // R4: history before clear must not count
    stream("011", "R4 prefix");
    do_clear(3, "R5 clear held");
    stream("0", "R4 no match after clear");
    stream("110", "R4 needs four");
    stream("0110", "R4 fresh match");

    // R5: clear while match is high
    stream("0110", "R5 setup");
    @(negedge clk_i);
    clear_i = 1'b1;
    #1;
    check(1'b0, "R5 drops at once");
    nbits = 0;
    hist = '0;
    @(negedge clk_i);
    clear_i = 1'b0;
    stream("0110", "R5 after release");

    // R6: reset mid stream
    stream("01", "R6 prefix");
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(1'b0, "R6 reset low");
    nbits = 0;
    hist = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    stream("10110", "R6 after reset");

    // R1 R7: pseudo-random stream
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], "R1 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule